// File: doc/BRIEF.md
# Card Bus Clock Divider

This block derives the clock that drives a memory card bus from a faster system clock. The ratio comes from a 16-bit rate word with two fields: a small integer divider and a power-of-two prescaler. A control strobe carries three commands: start, stop and soft reset. A status word reports whether the card clock is toggling. The card clock is a registered output, so it can never glitch. The clock runs high for the first half of each period and low for the rest.

A host writes the rate word and then issues a start. The rate word may be rewritten while the clock runs. A new ratio waits until the end of the period in progress, which is also the end of a low phase. A stop likewise lets the period in progress finish, so the card never sees a shortened pulse. The soft-reset command clears the divide counters at once. It may be followed by a burst of start commands, and the clock then comes out running from the start of a period.

Top module: `card_clk_gen`

## Requirements
- R1: After the reset input is released, the card clock is low, the status word is zero and the rate word is zero. A start with the reset-value rate word gives a period of 2 input cycles.
- R2: The divider field sits in rate bits [3:0] and the prescaler field in bits [15:4]. The period in input cycles is (D+1) when the prescaler is 0, and (D+1)*2*P otherwise. A divider field of 0 is treated as 1.
- R3: Each period is high for floor(period/2) input cycles and low for the remainder, so an even period has an exact 50% duty cycle. The first high phase begins at the clock edge that accepts the start command.
- R4: The shortest period is 2 input cycles (rate word 0x0001). The longest is 65536 input cycles (rate word 0x800F), which is high for 32768 cycles.
- R5: In a control write, bit 0 requests stop, bit 1 requests start and bit 3 requests soft reset. When stop and start are both set, stop wins.
- R6: A stop issued while running lets the current period complete, high and low phases at full length. The running flag stays set until the edge that ends that period.
- R7: A rate word written while running does not change the period in progress. The new ratio applies from the next period on.
- R8: A start issued while the clock is already running does not restart or shift its phase. Such a start also cancels a pending stop.
- R9: A soft reset drives the clock low and stops it at the next edge, and the rate word is kept. If the same write also sets start, and stop is clear, the clock restarts from the beginning of a period. The sequence of a reset alone, then reset with start, then eight starts leaves the clock running at the programmed rate.
- R10: Status bit 8 is 1 exactly while the card clock is running. All other status bits read 0.
- R11: While stopped, the card clock stays low and a newly written rate word is used by the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_wr_i | input | 1 | Write strobe for the rate word |
| rate_i | input | 16 | Rate word: divider [3:0], prescaler [15:4] |
| ctl_wr_i | input | 1 | Write strobe for the control command |
| ctl_i | input | 4 | Command bits: 0 stop, 1 start, 3 soft reset |
| card_clk_o | output | 1 | Divided card bus clock |
| status_o | output | 16 | Status word, bit 8 is the running flag |

## Verification
Most internal faults in this block appear at the ports within one period of the card clock. A counter that wraps at the wrong count changes the high or low length of the very next phase. A rate word loaded at the wrong moment shortens the period in progress. A stop or start that acts on the wrong edge moves the running flag or the first rising edge by a cycle. A reference model in the bench tracks the phase position every cycle, so any such fault shows up as a mismatch on the first cycle where the clock level or status differs. For the longest ratio, the first mismatch can come only after up to 65536 input cycles.

// File: rtl/ckg_pkg.sv
package ckg_pkg;

    // default field widths of the rate word
    localparam int unsigned CKG_DIV_W   = 4;
    localparam int unsigned CKG_PRE_W   = 12;

    // status word and its running flag position
    localparam int unsigned CKG_STAT_W  = 16;
    localparam int unsigned CKG_RUN_BIT = 8;

    // control command width and bit positions
    localparam int unsigned CKG_CTL_W   = 4;
    localparam int unsigned CKG_BIT_STOP  = 0;
    localparam int unsigned CKG_BIT_START = 1;
    localparam int unsigned CKG_BIT_SRST  = 3;

endpackage

// File: rtl/ckg_limits.sv
// Terminal counts of both divide stages for one rate word.
module ckg_limits #(
    parameter int unsigned DIV_W = 4,
    parameter int unsigned PRE_W = 12
) (
    input  logic [DIV_W+PRE_W-1:0] word_i,
    output logic [DIV_W-1:0]       div_o,
    output logic [PRE_W:0]         last_o
);
    localparam logic [PRE_W:0] ONE_C = (PRE_W+1)'(1);

    logic [PRE_W-1:0] pre;

    always_comb begin
        pre   = word_i[DIV_W+PRE_W-1:DIV_W];
        div_o = word_i[DIV_W-1:0];
        if (div_o == '0) begin
            div_o = DIV_W'(1);
        end
        if (pre == '0) begin
            last_o = '0;
        end else begin
            last_o = ({1'b0, pre} << 1) - ONE_C;
        end
    end
endmodule

// File: rtl/ckg_midpoint.sv
// Position (divider count, prescale count) at which the high phase ends.
module ckg_midpoint #(
    parameter int unsigned DIV_W = 4,
    parameter int unsigned PRE_W = 12
) (
    input  logic [DIV_W+PRE_W-1:0] word_i,
    output logic [DIV_W-1:0]       half_div_o,
    output logic [PRE_W:0]         half_pre_o
);
    localparam logic [DIV_W:0] ONE_C = (DIV_W+1)'(1);

    logic [DIV_W-1:0] div;
    logic [PRE_W-1:0] pre;
    logic [DIV_W:0]   steps;
    logic [DIV_W:0]   steps_half;

    always_comb begin
        pre = word_i[DIV_W+PRE_W-1:DIV_W];
        div = word_i[DIV_W-1:0];
        if (div == '0) begin
            div = DIV_W'(1);
        end
        steps      = {1'b0, div} + ONE_C;
        steps_half = steps >> 1;
        half_div_o = steps_half[DIV_W-1:0];
        // odd number of divider steps with prescaling: the midpoint
        // falls halfway through one prescale run
        if ((pre != '0) && !div[0]) begin
            half_pre_o = {1'b0, pre};
        end else begin
            half_pre_o = '0;
        end
    end
endmodule

// File: rtl/ckg_prescale.sv
// First divide stage: counts 0..last and emits a tick on the terminal count.
module ckg_prescale #(
    parameter int unsigned PRE_W = 12
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           clear_i,
    input  logic           run_i,
    input  logic [PRE_W:0] last_i,
    output logic [PRE_W:0] cnt_d_o,
    output logic           tick_o
);
    localparam logic [PRE_W:0] ONE_C = (PRE_W+1)'(1);

    typedef struct packed {
        logic [PRE_W:0] cnt;
    } pre_st_t;

    pre_st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        tick_o = 1'b0;
        if (clear_i) begin
            s_d.cnt = '0;
        end else if (run_i) begin
            if (s_q.cnt >= last_i) begin
                s_d.cnt = '0;
                tick_o  = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + ONE_C;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_d_o = s_d.cnt;

    // R2: prescale position never leaves the range of the active word
    p_pre_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.cnt <= last_i);
endmodule

// File: rtl/ckg_divstage.sv
// Second divide stage: advances on prescale ticks, counts 0..div.
module ckg_divstage #(
    parameter int unsigned DIV_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] div_i,
    output logic [DIV_W-1:0] cnt_d_o,
    output logic             wrap_o
);
    localparam logic [DIV_W-1:0] ONE_C = DIV_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        wrap_o = 1'b0;
        if (clear_i) begin
            s_d.cnt = '0;
        end else if (tick_i) begin
            if (s_q.cnt >= div_i) begin
                s_d.cnt = '0;
                wrap_o  = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + ONE_C;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_d_o = s_d.cnt;

    // R2: divider position stays within 0..div of the active word
    p_div_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.cnt <= div_i);
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
    import ckg_pkg::*;
#(
    parameter int unsigned DIV_W   = CKG_DIV_W,
    parameter int unsigned PRE_W   = CKG_PRE_W,
    parameter int unsigned STAT_W  = CKG_STAT_W,
    parameter int unsigned RUN_BIT = CKG_RUN_BIT,
    parameter int unsigned CTL_W   = CKG_CTL_W
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   rate_wr_i,
    input  logic [DIV_W+PRE_W-1:0] rate_i,
    input  logic                   ctl_wr_i,
    input  logic [CTL_W-1:0]       ctl_i,
    output logic                   card_clk_o,
    output logic [STAT_W-1:0]      status_o
);
    localparam int unsigned RW = DIV_W + PRE_W;

    typedef struct packed {
        logic [RW-1:0] rate;    // last written rate word
        logic [RW-1:0] act;     // word governing the current period
        logic          en;      // clock requested
        logic          active;  // clock toggling
        logic          clk;     // registered card clock
    } gen_st_t;

    gen_st_t s_d, s_q;

    logic             cmd_stop, cmd_start, cmd_srst;
    logic             ctl_unused;
    logic [RW-1:0]    rate_nx;
    logic [DIV_W-1:0] div_cur;
    logic [PRE_W:0]   last_cur;
    logic [DIV_W-1:0] half_div_nx;
    logic [PRE_W:0]   half_pre_nx;
    logic [PRE_W:0]   pre_cnt_d;
    logic [DIV_W-1:0] div_cnt_d;
    logic             pre_tick;
    logic             period_end;

    assign cmd_stop   = ctl_wr_i & ctl_i[CKG_BIT_STOP];
    assign cmd_start  = ctl_wr_i & ctl_i[CKG_BIT_START];
    assign cmd_srst   = ctl_wr_i & ctl_i[CKG_BIT_SRST];
    assign ctl_unused = ^ctl_i;
    assign rate_nx    = rate_wr_i ? rate_i : s_q.rate;

    ckg_limits #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_lim (
        .word_i (s_q.act),
        .div_o  (div_cur),
        .last_o (last_cur)
    );

    ckg_midpoint #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_mid (
        .word_i     (s_d.act),
        .half_div_o (half_div_nx),
        .half_pre_o (half_pre_nx)
    );

    ckg_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (cmd_srst),
        .run_i   (s_q.active),
        .last_i  (last_cur),
        .cnt_d_o (pre_cnt_d),
        .tick_o  (pre_tick)
    );

    ckg_divstage #(.DIV_W(DIV_W)) u_div (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (cmd_srst),
        .tick_i  (pre_tick),
        .div_i   (div_cur),
        .cnt_d_o (div_cnt_d),
        .wrap_o  (period_end)
    );

    always_comb begin
        s_d      = s_q;
        s_d.rate = rate_nx;
        if (cmd_srst) begin
            s_d.en     = cmd_start & ~cmd_stop;
            s_d.active = s_d.en;
            s_d.act    = rate_nx;
        end else begin
            if (cmd_stop) begin
                s_d.en = 1'b0;
            end else if (cmd_start) begin
                s_d.en = 1'b1;
            end
            if (!s_q.active) begin
                s_d.act    = rate_nx;
                s_d.active = s_d.en;
            end else if (period_end) begin
                s_d.act = rate_nx;
                if (!s_d.en) begin
                    s_d.active = 1'b0;
                end
            end
        end
        s_d.clk = s_d.active &&
                  ((div_cnt_d < half_div_nx) ||
                   ((div_cnt_d == half_div_nx) && (pre_cnt_d < half_pre_nx)));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        status_o          = '0;
        status_o[RUN_BIT] = s_q.active;
    end

    assign card_clk_o = s_q.clk;

    // R6: a stop only ends the clock after a low cycle, never mid-pulse
    p_stop_after_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(s_q.active) && !$past(cmd_srst)) |-> !$past(s_q.clk));

    // R7: the governing word is frozen inside a running period
    p_rate_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.active && !period_end && !cmd_srst) |=> $stable(s_q.act));

    // R3: every start begins with a high phase
    p_start_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.active) |-> s_q.clk);
endmodule

// File: tb/sim_card_clk_gen.sv
module sim_card_clk_gen;
    logic        clk;
    logic        rst_n;
    logic        rate_wr;
    logic [15:0] rate_in;
    logic        ctl_wr;
    logic [3:0]  ctl;
    logic        card_clk;
    logic [15:0] status;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    card_clk_gen u0 (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .rate_wr_i  (rate_wr),
        .rate_i     (rate_in),
        .ctl_wr_i   (ctl_wr),
        .ctl_i      (ctl),
        .card_clk_o (card_clk),
        .status_o   (status)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // ---------------- reference model ----------------
    logic [15:0] m_rate, m_cur;
    logic        m_en, m_act;
    int          m_pos;

    function automatic int ratio(input logic [15:0] w);
        int d, p;
        d = int'(w[3:0]);
        if (d == 0) d = 1;
        p = int'(w[15:4]);
        return (d + 1) * ((p == 0) ? 1 : 2 * p);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_rate = '0; m_cur = '0; m_en = 0; m_act = 0; m_pos = 0;
        end else begin
            logic [15:0] nrate;
            logic srst, stp, sta;
            nrate = rate_wr ? rate_in : m_rate;
            srst  = ctl_wr && ctl[3];
            stp   = ctl_wr && ctl[0];
            sta   = ctl_wr && ctl[1];
            if (srst) begin
                m_en  = sta && !stp;
                m_act = m_en;
                m_pos = 0;
                m_cur = nrate;
            end else begin
                if (stp) m_en = 0;
                else if (sta) m_en = 1;
                if (!m_act) begin
                    m_cur = nrate;
                    m_pos = 0;
                    m_act = m_en;
                end else if (m_pos == ratio(m_cur) - 1) begin
                    m_pos = 0;
                    m_cur = nrate;
                    if (!m_en) m_act = 0;
                end else begin
                    m_pos++;
                end
            end
            m_rate = nrate;
        end
    end

    // per-cycle comparison against the model (R3 R6 R7 R8 R9 R10)
    always @(negedge clk) begin
        if (rst_n) begin
            logic        e_clk;
            logic [15:0] e_stat;
            e_clk  = m_act && (m_pos < ratio(m_cur) / 2);
            e_stat = 16'(m_act) << 8;
            checks++;
            if (card_clk !== e_clk || status !== e_stat) begin
                fails++;
                $display("FAIL model compare R3 R10 cycle %0d actual clk=%0d stat=%0h expected clk=%0d stat=%0h",
                         cyc, card_clk, status, e_clk, e_stat);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog R4 actual=%0d expected<190000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- helpers (called at a negedge) ----------------
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put_rate(input logic [15:0] v);
        rate_wr = 1'b1; rate_in = v;
        @(negedge clk);
        rate_wr = 1'b0;
    endtask

    task automatic put_ctl(input logic [3:0] v);
        ctl_wr = 1'b1; ctl = v;
        @(negedge clk);
        ctl_wr = 1'b0; ctl = '0;
    endtask

    task automatic wait_rise();
        while (card_clk !== 1'b0) @(negedge clk);
        while (card_clk !== 1'b1) @(negedge clk);
    endtask

    task automatic skip(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic shape(input string req, input int exp_hi, input int exp_lo);
        int hi, lo;
        hi = 0; lo = 0;
        wait_rise();
        while (card_clk === 1'b1) begin hi++; @(negedge clk); end
        while (card_clk === 1'b0) begin lo++; @(negedge clk); end
        chk({req, " high cycles"}, hi, exp_hi);
        chk({req, " low cycles"}, lo, exp_lo);
    endtask

    initial begin
        rst_n = 1'b0; rate_wr = 0; rate_in = '0; ctl_wr = 0; ctl = '0;
        skip(3);
        rst_n = 1'b1;
        skip(3);
        // R1 reset state
        chk("R1 clock low after reset", card_clk, 0);
        chk("R1 status zero after reset", status, 0);

        // R1 R5 start with reset rate word: ratio 2
        put_ctl(4'b0010);
        chk("R3 first cycle after start is high", card_clk, 1);
        chk("R10 running flag set", status, 16'h0100);
        shape("R1 R4 fastest ratio", 1, 1);

        // R2 field positions and odd ratio
        put_rate(16'h0002);
        shape("R2 bypass div 2", 1, 2);
        put_rate(16'h0012);
        shape("R3 prescale 1 div 2 duty", 3, 3);
        put_rate(16'h0045);
        shape("R2 prescale 4 div 5", 24, 24);
        put_rate(16'h0030);
        shape("R2 divider zero as one", 6, 6);
        put_rate(16'h0003);
        shape("R2 bypass div 3", 2, 2);
        put_rate(16'h800F);
        shape("R4 slowest ratio", 32768, 32768);

        // R7 rate change mid-period keeps current period
        put_rate(16'h0007);
        wait_rise();
        put_rate(16'h0001);
        chk("R7 old high phase continues", card_clk, 1);
        skip(2);
        chk("R7 old high phase full length", card_clk, 1);
        skip(1);
        chk("R7 old low phase starts", card_clk, 0);
        shape("R7 new ratio after boundary", 1, 1);

        // R8 start while running keeps phase
        put_rate(16'h0007);
        wait_rise();
        wait_rise();
        put_ctl(4'b0010);
        skip(2);
        chk("R8 high phase unchanged", card_clk, 1);
        skip(1);
        chk("R8 no phase restart", card_clk, 0);

        // R6 stop completes the period
        wait_rise();
        put_ctl(4'b0001);
        chk("R6 still running after stop", status[8], 1);
        skip(2);
        chk("R6 high phase not cut", card_clk, 1);
        skip(4);
        chk("R6 running through low phase", status[8], 1);
        skip(1);
        chk("R6 stopped at period end", status[8], 0);

        // R11 stopped: clock low, new rate used by next start
        put_rate(16'h0003);
        skip(5);
        chk("R11 clock low while stopped", card_clk, 0);
        put_ctl(4'b0010);
        shape("R11 new rate after start", 2, 2);

        // R5 stop wins over start
        put_ctl(4'b0011);
        skip(6);
        chk("R5 stop wins when running", status[8], 0);
        put_ctl(4'b0011);
        skip(2);
        chk("R5 stop wins when stopped", status[8], 0);

        // R9 soft reset alone stops at once, rate kept
        put_ctl(4'b0010);
        skip(1);
        put_ctl(4'b1000);
        chk("R9 soft reset clock low", card_clk, 0);
        chk("R9 soft reset stopped", status, 0);
        // R9 full reset sequence comes out running
        put_ctl(4'b1000);
        put_ctl(4'b1010);
        for (int i = 0; i < 8; i++) put_ctl(4'b0010);
        chk("R9 running after sequence", status, 16'h0100);
        shape("R9 rate kept across soft reset", 2, 2);

        skip(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule